// File: doc/BRIEF.md
# Dual-Path Alternating Clock Root Selector

This block is one clock root slice. It picks one of eight source clocks and sends it through one of two parallel paths to a shared post-divider. Each path has its own source selector, a gate and an optional pre-divider. A two-way output mux chooses which path drives the post-divider. All clocks are modelled as single-cycle enable strobes in one reference clock domain, so every source is an input strobe and the slice output is also a strobe.

Software changes the source with one select write. The slice does not rewrite the path that is driving the output. It loads the new source into the other path, gates that path on and runs a switch handshake. The output mux then moves to the new path, and the old path is gated off. A one-bit toggle sends each accepted write to the path that is currently idle. Writing the same value twice therefore leaves both selectors on one source, with only the active path gated.

The handshake needs the new source to be running. If it is stopped, the slice stays busy forever. An optional timeout flags that condition with a sticky error. A core-style variant removes the pre-dividers. A status word returns both selectors, the slice enable, the active path, the gate states, busy and error.

Top module: `clk_root_slice`

## Requirements
- R1: After reset both selectors hold source 0, path A is active and only path A is gated on. Busy and error are 0, and the first accepted write goes to path B.
- R2: Each accepted write loads its value into the selector of the path that is not driving the output. When the switch completes, that path becomes active, so successive writes target B, A, B, A and so on.
- R3: The status word has these fields: bits 26:24 hold path A's selector, bits 10:8 hold path B's selector and bit 28 holds `slice_en`. Bit 0 is the active path (0 = A, 1 = B), bit 1 is busy, bit 2 is error, bit 4 is path A's gate and bit 5 is path B's gate. All other bits read 0.
- R4: Busy is 1 from the cycle after an accepted write. The slice first counts two strobes of the new path's source; strobes of the old source before that are not counted. It then counts two strobes of the old path's source. The output mux moves and busy falls on the edge that takes the second old-source strobe.
- R5: While a switch is in progress both gates are on. The outgoing path's gate turns off on the same edge as the mux switch. While idle, exactly one gate is on: the active path's gate.
- R6: A write that arrives while busy is ignored. It changes neither selector nor the toggle.
- R7: Writing the same select value twice leaves both selectors on that value, with only the active path gated on.
- R8: If the target path's source is stopped, the slice stays busy indefinitely and the active path does not change. The switch completes once the source runs again.
- R9: With the timeout enabled, the error bit sets after `TMO_CYCLES` consecutive busy cycles. It stays set, even after the switch completes, until reset.
- R10: `clk_out_tick` has one strobe for every (pre+1)·(post+1) strobes of the active source, where pre is `cfg_pre_div` and post is `cfg_post_div`. With `HAS_PREDIV` = 0 it has one strobe for every (post+1) strobes. The output is registered.
- R11: While `slice_en` is 0, `clk_out_tick` stays 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 8 | One enable strobe per source clock |
| slice_en | input | 1 | Slice output enable |
| cfg_pre_div | input | 3 | Pre-divider ratio minus one (both paths) |
| cfg_post_div | input | 3 | Post-divider ratio minus one |
| wr_en | input | 1 | Select write strobe |
| wr_sel | input | 3 | Source index carried by the write |
| clk_out_tick | output | 1 | Divided output strobe |
| busy | output | 1 | Switch handshake in progress |
| err_timeout | output | 1 | Sticky switch timeout flag |
| status | output | 32 | Readback word, layout in R3 |

## Verification
The status word, busy and error come straight from registers. They are therefore due one cycle after the edge that accepts a write or consumes a source strobe. The bench drives every input at a falling edge and reads the outputs at the next falling edge, after exactly one rising edge. For the handshake, it pulses individual source strobes by hand and checks busy, the active path and the gates after each pulse. The error bit is checked a few cycles before and a few cycles after the `TMO_CYCLES` boundary, so that it is not sampled on the exact edge. Output strobe counts are measured over a 720-cycle window and allow ±1 to absorb the divider phase.

// File: rtl/clk_root_pkg.sv
`timescale 1ns/1ps
package clk_root_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_NEW  = 2'd1,
      PH_OLD  = 2'd2
   } sw_phase_e;

   localparam int PATH_A = 0;
   localparam int PATH_B = 1;

   localparam int ST_W         = 32;
   localparam int ST_ACT_BIT   = 0;
   localparam int ST_BUSY_BIT  = 1;
   localparam int ST_ERR_BIT   = 2;
   localparam int ST_GATE_LSB  = 4;
   localparam int ST_SEL_B_LSB = 8;
   localparam int ST_SEL_A_LSB = 24;
   localparam int ST_EN_BIT    = 28;
   localparam int ST_SEL_FLD   = 3;

endpackage

// File: rtl/clk_tick_div.sv
`timescale 1ns/1ps
module clk_tick_div #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_in,
   input  logic [DIV_W-1:0] ratio,
   output logic             tick_out
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap     = (cnt_q >= ratio);
   assign tick_out = tick_in && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_in) begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end

   if (DIV_W < 1) begin : g_bad_div_w
      $error("clk_tick_div: DIV_W must be at least 1");
   end

endmodule

// File: rtl/clk_root_path.sv
`timescale 1ns/1ps
module clk_root_path #(
   parameter int SEL_W      = 3,
   parameter int DIV_W      = 3,
   parameter bit HAS_PREDIV = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<SEL_W)-1:0]   src_tick,
   input  logic [SEL_W-1:0]        sel,
   input  logic                    gate_en,
   input  logic [DIV_W-1:0]        pre_ratio,
   output logic                    tick_gated,
   output logic                    tick_out
);

   assign tick_gated = src_tick[sel] && gate_en;

   if (HAS_PREDIV) begin : g_prediv
      clk_tick_div #(.DIV_W(DIV_W)) u_pre (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_in  (tick_gated),
         .ratio    (pre_ratio),
         .tick_out (tick_out)
      );
   end else begin : g_bypass
      assign tick_out = tick_gated;
   end

endmodule

// File: rtl/clk_path_switch_ctrl.sv
`timescale 1ns/1ps
module clk_path_switch_ctrl
   import clk_root_pkg::*;
#(
   parameter int SEL_W      = 3,
   parameter bit TMO_EN     = 1'b1,
   parameter int TMO_CYCLES = 128
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [1:0]            tick_path,
   output logic [1:0][SEL_W-1:0] sel_q,
   output logic [1:0]            gate_q,
   output logic                  act_q,
   output logic                  busy,
   output logic                  err
);

   localparam int TMO_W   = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
   localparam int TMO_LIM = TMO_CYCLES - 1;

   sw_phase_e ph_q;
   logic      tgl_q;
   logic      tgt_q;
   logic      cnt_q;
   logic      busy_q;
   logic      wr_ok;

   assign wr_ok = wr_en && (ph_q == PH_IDLE);
   assign busy  = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         gate_q <= 2'b01;
         act_q  <= 1'b0;
         tgl_q  <= 1'b1;
         tgt_q  <= 1'b1;
         cnt_q  <= 1'b0;
         busy_q <= 1'b0;
         ph_q   <= PH_IDLE;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (wr_ok) begin
                  sel_q[tgl_q]  <= wr_sel;
                  gate_q[tgl_q] <= 1'b1;
                  tgt_q         <= tgl_q;
                  tgl_q         <= ~tgl_q;
                  cnt_q         <= 1'b0;
                  busy_q        <= 1'b1;
                  ph_q          <= PH_NEW;
               end
            end
            PH_NEW: begin
               if (tick_path[tgt_q]) begin
                  if (cnt_q) begin
                     cnt_q <= 1'b0;
                     ph_q  <= PH_OLD;
                  end else begin
                     cnt_q <= 1'b1;
                  end
               end
            end
            PH_OLD: begin
               if (tick_path[act_q]) begin
                  if (cnt_q) begin
                     cnt_q         <= 1'b0;
                     gate_q[act_q] <= 1'b0;
                     act_q         <= tgt_q;
                     busy_q        <= 1'b0;
                     ph_q          <= PH_IDLE;
                  end else begin
                     cnt_q <= 1'b1;
                  end
               end
            end
            default: begin
               ph_q   <= PH_IDLE;
               busy_q <= 1'b0;
            end
         endcase
      end
   end

   if (TMO_EN) begin : g_tmo
      logic [TMO_W-1:0] tmo_q;
      logic             err_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tmo_q <= '0;
            err_q <= 1'b0;
         end else if (wr_ok) begin
            tmo_q <= '0;
         end else if (busy_q && !err_q) begin
            if (tmo_q == TMO_W'(TMO_LIM)) begin
               err_q <= 1'b1;
            end else begin
               tmo_q <= tmo_q + 1'b1;
            end
         end
      end

      assign err = err_q;

      AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         err_q |=> err_q); // R9
   end else begin : g_no_tmo
      assign err = 1'b0;
   end

   if (TMO_CYCLES < 2) begin : g_bad_tmo
      $error("clk_path_switch_ctrl: TMO_CYCLES must be at least 2");
   end

   AST_WR_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy_q) |=> busy_q); // R4

   AST_NO_TICK_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (tick_path == 2'b00)) |=> busy_q); // R4

   AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(sel_q)); // R6

   AST_IDLE_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (($countones(gate_q) == 1) && gate_q[act_q])); // R5

   AST_BUSY_BOTH_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (gate_q == 2'b11)); // R5

   AST_TARGET_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (tgl_q != act_q)); // R2

endmodule

// File: rtl/clk_root_slice.sv
`timescale 1ns/1ps
module clk_root_slice
   import clk_root_pkg::*;
#(
   parameter int SEL_W      = 3,
   parameter int DIV_W      = 3,
   parameter bit HAS_PREDIV = 1'b1,
   parameter bit TMO_EN     = 1'b1,
   parameter int TMO_CYCLES = 128
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [(1<<SEL_W)-1:0]   src_tick,
   input  logic                    slice_en,
   input  logic [DIV_W-1:0]        cfg_pre_div,
   input  logic [DIV_W-1:0]        cfg_post_div,
   input  logic                    wr_en,
   input  logic [SEL_W-1:0]        wr_sel,
   output logic                    clk_out_tick,
   output logic                    busy,
   output logic                    err_timeout,
   output logic [ST_W-1:0]         status
);

   localparam int NUM_SRC = 1 << SEL_W;

   logic [1:0][SEL_W-1:0] sel_q;
   logic [1:0]            gate_q;
   logic                  act_q;
   logic [1:0]            tick_gated;
   logic [1:0]            tick_pre;
   logic                  mux_tick;
   logic                  post_tick;
   logic                  out_q;

   clk_path_switch_ctrl #(
      .SEL_W      (SEL_W),
      .TMO_EN     (TMO_EN),
      .TMO_CYCLES (TMO_CYCLES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .tick_path (tick_gated),
      .sel_q     (sel_q),
      .gate_q    (gate_q),
      .act_q     (act_q),
      .busy      (busy),
      .err       (err_timeout)
   );

   for (genvar p = 0; p < 2; p++) begin : g_path
      clk_root_path #(
         .SEL_W      (SEL_W),
         .DIV_W      (DIV_W),
         .HAS_PREDIV (HAS_PREDIV)
      ) u_path (
         .clk        (clk),
         .rst_n      (rst_n),
         .src_tick   (src_tick),
         .sel        (sel_q[p]),
         .gate_en    (gate_q[p]),
         .pre_ratio  (cfg_pre_div),
         .tick_gated (tick_gated[p]),
         .tick_out   (tick_pre[p])
      );
   end

   assign mux_tick = act_q ? tick_pre[PATH_B] : tick_pre[PATH_A];

   clk_tick_div #(.DIV_W(DIV_W)) u_post (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (mux_tick),
      .ratio    (cfg_post_div),
      .tick_out (post_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else begin
         out_q <= slice_en && post_tick;
      end
   end

   assign clk_out_tick = out_q;

   always_comb begin
      status                                     = '0;
      status[ST_ACT_BIT]                         = act_q;
      status[ST_BUSY_BIT]                        = busy;
      status[ST_ERR_BIT]                         = err_timeout;
      status[ST_GATE_LSB +: 2]                   = gate_q;
      status[ST_SEL_A_LSB +: ST_SEL_FLD]         = ST_SEL_FLD'(sel_q[PATH_A]);
      status[ST_SEL_B_LSB +: ST_SEL_FLD]         = ST_SEL_FLD'(sel_q[PATH_B]);
      status[ST_EN_BIT]                          = slice_en;
   end

   if ((SEL_W < 1) || (SEL_W > ST_SEL_FLD)) begin : g_bad_sel_w
      $error("clk_root_slice: SEL_W must be 1..3 to fit the status fields");
   end
   if (NUM_SRC < 2) begin : g_bad_src
      $error("clk_root_slice: at least two sources are required");
   end

   AST_OUT_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !slice_en |=> !clk_out_tick); // R11

   AST_STATUS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_EN_BIT] == slice_en); // R3

endmodule

// File: tb/test_clk_root_slice.sv
`timescale 1ns/1ps
module test_clk_root_slice;

   localparam int SEL_W = 3;
   localparam int DIV_W = 3;
   localparam int NSRC  = 8;
   localparam int TMO   = 128;
   localparam int WIN   = 720;

   // {expected active, written select, expected sel A, expected sel B}
   localparam logic [9:0] VEC [6] = '{
      10'b1_011_000_011,
      10'b0_011_011_011,
      10'b1_101_011_101,
      10'b0_001_001_101,
      10'b1_111_001_111,
      10'b0_010_010_111
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   run = '1;
   logic [NSRC-1:0]   man_tick = '0;
   logic              man_mode = 1'b0;
   logic [NSRC-1:0]   auto_tick;
   logic [NSRC-1:0]   src_tick;
   logic [31:0]       tcnt = '0;
   logic              slice_en = 1'b1;
   logic [DIV_W-1:0]  cfg_pre_div = 3'd1;
   logic [DIV_W-1:0]  cfg_post_div = 3'd2;
   logic              wr_en = 1'b0;
   logic [SEL_W-1:0]  wr_sel = '0;
   logic              out_tick, busy, err;
   logic [31:0]       status;
   logic              core_tick, core_busy, core_err;
   logic [31:0]       core_status;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   always_ff @(posedge clk) tcnt <= tcnt + 1;

   always_comb begin
      for (int i = 0; i < NSRC; i++) begin
         auto_tick[i] = run[i] && ((tcnt % (i + 2)) == 0);
      end
      src_tick = man_mode ? man_tick : auto_tick;
   end

   clk_root_slice #(.TMO_CYCLES(TMO)) i_clk_root_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_tick     (src_tick),
      .slice_en     (slice_en),
      .cfg_pre_div  (cfg_pre_div),
      .cfg_post_div (cfg_post_div),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .clk_out_tick (out_tick),
      .busy         (busy),
      .err_timeout  (err),
      .status       (status)
   );

   clk_root_slice #(.HAS_PREDIV(1'b0), .TMO_CYCLES(TMO)) i_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_tick     (src_tick),
      .slice_en     (slice_en),
      .cfg_pre_div  (cfg_pre_div),
      .cfg_post_div (cfg_post_div),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .clk_out_tick (core_tick),
      .busy         (core_busy),
      .err_timeout  (core_err),
      .status       (core_status)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_range(input string req, input int act, input int lo, input int hi);
      tests++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_write(input logic [SEL_W-1:0] v);
      wr_en  = 1'b1;
      wr_sel = v;
      @(negedge clk);
      wr_en  = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      for (int i = 0; i < 300; i++) begin
         if (!busy) break;
         @(negedge clk);
      end
      chk(req, int'(busy), 0);
   endtask

   task automatic pulse(input int k);
      man_tick[k] = 1'b1;
      @(negedge clk);
      man_tick[k] = 1'b0;
   endtask

   task automatic check_state(input string req, input int act, input int sa,
                              input int sb, input int gates);
      chk({req, " active"}, int'(status[0]), act);
      chk({req, " selA"},   int'(status[26:24]), sa);
      chk({req, " selB"},   int'(status[10:8]), sb);
      chk({req, " gates"},  int'(status[5:4]), gates);
   endtask

   task automatic measure(input string req, output int main_n, output int core_n);
      main_n = 0;
      core_n = 0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk);
         main_n += int'(out_tick);
         core_n += int'(core_tick);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int mn, cn;
      do_reset();

      // R1 / R3: reset state and status layout
      chk("R1 status word", int'(status), (1 << 28) | (1 << 4));
      chk("R1 busy", int'(busy), 0);
      chk("R1 error", int'(err), 0);
      chk("R3 enable bit", int'(status[28]), 1);

      // R2 / R3 / R7: vector table
      foreach (VEC[k]) begin
         do_write(VEC[k][8:6]);
         chk("R4 busy after write", int'(status[1]), 1);
         wait_idle("R2 switch done");
         check_state("R2 vector", int'(VEC[k][9]), int'(VEC[k][5:3]),
                     int'(VEC[k][2:0]), VEC[k][9] ? 2 : 1);
         if (k == 1) begin
            chk("R7 same source", int'(status[26:24]), int'(status[10:8]));
         end
      end

      // R6: write while busy ignored; R5: both gates on during switch
      do_write(3'd6);
      chk("R4 busy", int'(busy), 1);
      chk("R5 both gates", int'(status[5:4]), 3);
      chk("R4 active held", int'(status[0]), 0);
      do_write(3'd1);
      wait_idle("R6 idle");
      check_state("R6 held off", 1, 2, 6, 2);

      // R10: rate, source 6 period 8
      measure("R10", mn, cn);
      chk_range("R10 prediv rate", mn, 14, 16);
      chk_range("R10 core rate", cn, 29, 31);

      // R11: slice disabled
      slice_en = 1'b0;
      @(negedge clk);
      chk("R3 enable bit low", int'(status[28]), 0);
      measure("R11", mn, cn);
      chk("R11 no ticks", mn, 0);
      chk("R11 no ticks core", cn, 0);
      slice_en = 1'b1;

      // R8 / R9: stopped target source
      run[4] = 1'b0;
      do_write(3'd4);
      repeat (118) @(negedge clk);
      chk("R8 still busy", int'(busy), 1);
      chk("R8 active unchanged", int'(status[0]), 1);
      chk("R9 no error yet", int'(err), 0);
      repeat (15) @(negedge clk);
      chk("R9 error set", int'(err), 1);
      chk("R9 status error bit", int'(status[2]), 1);
      chk("R8 busy forever", int'(busy), 1);
      run[4] = 1'b1;
      wait_idle("R8 resumes");
      chk("R8 switched", int'(status[0]), 0);
      chk("R9 sticky", int'(err), 1);
      do_reset();
      chk("R9 reset clears", int'(err), 0);
      chk("R1 reset again", int'(status), (1 << 28) | (1 << 4));

      // R4: exact handshake with manual strobes
      man_mode = 1'b1;
      man_tick = '0;
      do_write(3'd3);
      pulse(0);
      pulse(0);
      chk("R4 old ticks ignored first", int'(busy), 1);
      pulse(3);
      chk("R4 one new tick", int'(busy), 1);
      pulse(3);
      chk("R4 two new ticks", int'(busy), 1);
      chk("R4 not yet switched", int'(status[0]), 0);
      pulse(0);
      chk("R4 one old tick", int'(busy), 1);
      pulse(0);
      chk("R4 done", int'(busy), 0);
      check_state("R5 switch", 1, 0, 3, 2);
      man_mode = 1'b0;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule